// File: doc/BRIEF.md
# Integer Multiply/Divide Unit with HI/LO Pair

This unit provides 32-bit integer multiplication and division for a simple in-order processor core. It holds two result registers: HI and LO. A multiply writes the full 64-bit product across the pair in a single clock. A divide leaves the quotient in LO and the remainder in HI. The host core may also load either register directly, and reads either one through a combinational read port.

Division is iterative. A restoring shift-subtract loop works on operand magnitudes and retires one quotient bit per cycle. The signs of the quotient and remainder are corrected on the last step. While the loop runs, `busy` is high. A read request made during that time raises `stall`, so the host holds the reading instruction until the result has been written.

The unit never signals an error. Division by zero and the signed overflow case each produce a fixed result pair. A new operation issued in the middle of a divide replaces the divide.

Top module: `mdu_hilo`

## Requirements
- R1: After reset, HI and LO are both zero, `busy` is low, and `stall` is low even when a read is requested.
- R2: `op` code 0 is the signed multiply. It writes the low 32 bits of the 64-bit two's-complement product to LO and the high 32 bits to HI. Both are readable on the cycle after the start cycle, and `busy` is never raised.
- R3: `op` code 1 is the unsigned multiply. It writes the full 64-bit unsigned product the same way, also in one cycle.
- R4: `op` code 2 is the signed divide. It puts the quotient, truncated toward zero, in LO. It puts the remainder in HI, with the same sign as the dividend. `busy` is high for exactly 32 cycles after the start cycle, and both results are valid once `busy` falls.
- R5: `op` code 3 is the unsigned divide. It gives the unsigned quotient in LO and the remainder in HI, with the same 32-cycle timing.
- R6: A signed divide by zero sets HI to the dividend. It sets LO to 0x00000001 if the dividend is negative, and to 0xFFFFFFFF otherwise.
- R7: A signed divide of 0x80000000 by 0xFFFFFFFF sets LO to 0x80000000 and HI to 0.
- R8: An unsigned divide by zero sets LO to 0xFFFFFFFF and HI to the dividend.
- R9: `op` code 4 copies `opa` into HI, and `op` code 5 copies `opa` into LO. Each takes effect in one cycle and leaves the other register unchanged.
- R10: `rd_data` shows HI when `rd_sel` is 1 and LO when `rd_sel` is 0. `stall` equals `rd_req` while `busy` is high. HI and LO keep their old values until the divide's final step.
- R11: A valid start during a divide abandons that divide. A new divide then runs a full 32 cycles on the new operands. A multiply or move completes at once and drops `busy`.
- R12: `op` codes 6 and 7 are ignored. They change neither HI nor LO, and they neither start nor abandon a divide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue the operation on `op` this cycle |
| op | input | 3 | Operation code (0 to 5 valid) |
| opa | input | 32 | First operand / dividend / value to move |
| opb | input | 32 | Second operand / divisor |
| rd_req | input | 1 | Host wants to read HI or LO this cycle |
| rd_sel | input | 1 | 1 selects HI, 0 selects LO |
| rd_data | output | 32 | Selected register contents |
| stall | output | 1 | Read must wait; result not yet written |
| busy | output | 1 | Divide in progress |

## Verification
A wrong iteration count or a badly initialised partial remainder leaves a wrong quotient or remainder in LO/HI. It also moves the falling edge of `busy` away from cycle 32, so the bench checks both the busy length and the values as soon as `busy` drops. A wrong sign-fix flag shows up only for negative operands, and only in the final write; the signed vectors and the zero-divisor cases expose it on the first read after completion. Faults in the restart and ignore logic show up as a divide that ends too early or too late relative to the interfering start.

// File: rtl/mdu_hilo.sv
module mdu_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         rd_req,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data,
  output logic         stall,
  output logic         busy
);

  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [2:0] OP_MULS = 3'd0, OP_MULU = 3'd1, OP_DIVS = 3'd2,
                         OP_DIVU = 3'd3, OP_WHI  = 3'd4, OP_WLO  = 3'd5;

  logic [W-1:0]  hi, lo;
  logic [W-1:0]  rem, quo, dvs;
  logic          neg_q, neg_r;
  logic [CW-1:0] cnt;

  logic is_mul, is_div, sgn, valid_op;
  assign is_mul   = (op == OP_MULS) || (op == OP_MULU);
  assign is_div   = (op == OP_DIVS) || (op == OP_DIVU);
  assign sgn      = (op == OP_MULS) || (op == OP_DIVS);
  assign valid_op = (op <= OP_WLO);

  logic [2*W-1:0] xa, xb, prod;
  assign xa   = {{W{sgn & opa[W-1]}}, opa};
  assign xb   = {{W{sgn & opb[W-1]}}, opb};
  assign prod = xa * xb;

  logic a_neg, b_neg;
  logic [W-1:0] mag_a, mag_b;
  assign a_neg = sgn & opa[W-1];
  assign b_neg = sgn & opb[W-1];
  assign mag_a = a_neg ? -opa : opa;
  assign mag_b = b_neg ? -opb : opb;

  logic [W:0]   sh;
  logic [W+1:0] diff;
  logic         ge;
  logic [W-1:0] nrem, nquo, fq, fr;
  assign sh   = {rem, quo[W-1]};
  assign diff = {1'b0, sh} - {2'b00, dvs};
  assign ge   = ~diff[W+1];
  assign nrem = ge ? diff[W-1:0] : sh[W-1:0];
  assign nquo = {quo[W-2:0], ge};
  assign fq   = neg_q ? -nquo : nquo;
  assign fr   = neg_r ? -nrem : nrem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi <= '0; lo <= '0; rem <= '0; quo <= '0; dvs <= '0;
      neg_q <= 1'b0; neg_r <= 1'b0; cnt <= '0; busy <= 1'b0;
    end else if (start && valid_op) begin
      if (is_mul) begin
        {hi, lo} <= prod;
        busy <= 1'b0;
      end else if (is_div) begin
        rem   <= '0;
        quo   <= mag_a;
        dvs   <= mag_b;
        neg_q <= a_neg ^ b_neg;
        neg_r <= a_neg;
        cnt   <= '0;
        busy  <= 1'b1;
      end else if (op == OP_WHI) begin
        hi   <= opa;
        busy <= 1'b0;
      end else begin
        lo   <= opa;
        busy <= 1'b0;
      end
    end else if (busy) begin
      rem <= nrem;
      quo <= nquo;
      cnt <= cnt + 1'b1;
      if (cnt == LAST) begin
        hi   <= fr;
        lo   <= fq;
        busy <= 1'b0;
      end
    end
  end

  assign rd_data = rd_sel ? hi : lo;
  assign stall   = rd_req & busy;

  assert_div_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start && is_div |=> busy && cnt == '0);
  assert_mul_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && is_mul |=> !busy);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !start && cnt != LAST |=> busy && $stable(hi) && $stable(lo));
  assert_finish_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !start && cnt == LAST |=> !busy);
  assert_move_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start && op == OP_WHI |=> hi == $past(opa) && $stable(lo));
  assert_move_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start && op == OP_WLO |=> lo == $past(opa) && $stable(hi));
  assert_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start && !valid_op && !busy |=> !busy && $stable(hi) && $stable(lo));
  assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && is_div |=> busy && cnt == '0);

endmodule

// File: tb/tb_mdu_hilo.sv
module tb_mdu_hilo;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rd_req = 1'b0, rd_sel = 1'b0;
  logic [2:0] op = '0;
  logic [31:0] opa = '0, opb = '0, rd_data;
  logic stall, busy;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  mdu_hilo dut (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
                .rd_req(rd_req), .rd_sel(rd_sel), .rd_data(rd_data), .stall(stall), .busy(busy));

  localparam int NV = 13;
  localparam logic [2:0] T_OP [NV] = '{3'd0, 3'd0, 3'd1, 3'd1, 3'd2, 3'd2, 3'd3,
                                       3'd2, 3'd2, 3'd2, 3'd3, 3'd2, 3'd3};
  localparam logic [31:0] T_A [NV] = '{32'd7, 32'h80000000, 32'hFFFFFFFF, 32'h12345678,
                                       32'hFFFFFFF9, 32'd7, 32'hFFFFFFFF, 32'h80000000,
                                       32'hFFFFFF00, 32'h00001234, 32'hDEADBEEF, 32'd100, 32'd5};
  localparam logic [31:0] T_B [NV] = '{32'hFFFFFFFD, 32'h80000000, 32'hFFFFFFFF, 32'h9ABCDEF0,
                                       32'd2, 32'hFFFFFFFE, 32'd16, 32'hFFFFFFFF,
                                       32'd0, 32'd0, 32'd0, 32'd7, 32'd9};

  function automatic logic [63:0] ref_res(logic [2:0] o, logic [31:0] a, logic [31:0] b);
    longint sa, sb;
    longint unsigned ua, ub;
    int ia, ib;
    logic [31:0] h, l;
    h = '0; l = '0;
    case (o)
      3'd0: begin sa = longint'($signed(a)); sb = longint'($signed(b)); {h, l} = 64'(sa * sb); end
      3'd1: begin ua = {32'd0, a}; ub = {32'd0, b}; {h, l} = 64'(ua * ub); end
      3'd2: begin
        if (b == 0) begin h = a; l = a[31] ? 32'd1 : 32'hFFFFFFFF; end
        else if (a == 32'h80000000 && b == 32'hFFFFFFFF) begin l = 32'h80000000; h = 0; end
        else begin ia = int'(a); ib = int'(b); l = 32'(ia / ib); h = 32'(ia % ib); end
      end
      default: begin
        if (b == 0) begin l = 32'hFFFFFFFF; h = a; end
        else begin l = a / b; h = a % b; end
      end
    endcase
    return {h, l};
  endfunction

  function automatic string tag_of(logic [2:0] o, logic [31:0] a, logic [31:0] b);
    if (o == 3'd0) return "R2";
    if (o == 3'd1) return "R3";
    if (o == 3'd3) return (b == 0) ? "R8" : "R5";
    if (b == 0) return "R6";
    if (a == 32'h80000000 && b == 32'hFFFFFFFF) return "R7";
    return "R4";
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] o, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    start = 1'b1; op = o; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
  endtask

  task automatic read_hl(output logic [31:0] h, output logic [31:0] l);
    rd_sel = 1'b0; #1 l = rd_data;
    rd_sel = 1'b1; #1 h = rd_data;
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] h, l, ph, pl;
    logic [63:0] e;
    int n;
    repeat (3) @(negedge clk);
    rd_req = 1'b1;
    read_hl(h, l);
    chk("R1", "reset HI", h, 0);
    chk("R1", "reset LO", l, 0);
    chk("R1", "reset busy", {31'd0, busy}, 0);
    chk("R1", "reset stall", {31'd0, stall}, 0);
    rd_req = 1'b0;
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(T_OP[i], T_A[i], T_B[i]);
      wait_idle(n);
      chk(tag_of(T_OP[i], T_A[i], T_B[i]), "busy cycles", n, (T_OP[i] >= 3'd2) ? 32 : 0);
      read_hl(h, l);
      e = ref_res(T_OP[i], T_A[i], T_B[i]);
      chk(tag_of(T_OP[i], T_A[i], T_B[i]), "HI", h, e[63:32]);
      chk(tag_of(T_OP[i], T_A[i], T_B[i]), "LO", l, e[31:0]);
    end

    issue(3'd2, 32'h80000000, 32'hFFFFFFFF);
    wait_idle(n);
    read_hl(h, l);
    chk("R7", "overflow LO", l, 32'h80000000);
    chk("R7", "overflow HI", h, 32'h0);
    issue(3'd2, 32'hFFFFFFF0, 32'd0);
    wait_idle(n);
    read_hl(h, l);
    chk("R6", "neg by zero LO", l, 32'h1);
    chk("R6", "neg by zero HI", h, 32'hFFFFFFF0);

    read_hl(ph, pl);
    issue(3'd4, 32'hCAFEF00D, 32'd0);
    read_hl(h, l);
    chk("R9", "move HI", h, 32'hCAFEF00D);
    chk("R9", "LO kept", l, pl);
    issue(3'd5, 32'h0BADF00D, 32'd0);
    read_hl(h, l);
    chk("R9", "move LO", l, 32'h0BADF00D);
    chk("R9", "HI kept", h, 32'hCAFEF00D);

    issue(3'd3, 32'd100, 32'd7);
    rd_req = 1'b1; rd_sel = 1'b1; #1;
    chk("R10", "stall while busy", {31'd0, stall}, 1);
    chk("R10", "HI held during divide", rd_data, 32'hCAFEF00D);
    wait_idle(n);
    #1;
    chk("R10", "stall released", {31'd0, stall}, 0);
    read_hl(h, l);
    chk("R10", "rd_sel HI", h, 32'd2);
    chk("R10", "rd_sel LO", l, 32'd14);
    rd_req = 1'b0;

    issue(3'd3, 32'd1000, 32'd3);
    repeat (3) @(negedge clk);
    issue(3'd2, 32'hFFFFFF9C, 32'd7);
    wait_idle(n);
    chk("R11", "restart busy cycles", n, 32);
    read_hl(h, l);
    chk("R11", "restart LO", l, 32'hFFFFFFF2);
    chk("R11", "restart HI", h, 32'hFFFFFFFE);
    issue(3'd3, 32'd50, 32'd5);
    repeat (2) @(negedge clk);
    issue(3'd1, 32'd3, 32'd4);
    chk("R11", "multiply aborts divide", {31'd0, busy}, 0);
    read_hl(h, l);
    chk("R11", "abort LO", l, 32'd12);
    chk("R11", "abort HI", h, 32'd0);

    issue(3'd6, 32'h11111111, 32'h22222222);
    read_hl(h, l);
    chk("R12", "idle ignore LO", l, 32'd12);
    chk("R12", "idle ignore HI", h, 32'd0);
    chk("R12", "idle ignore busy", {31'd0, busy}, 0);
    issue(3'd3, 32'd81, 32'd9);
    repeat (2) @(negedge clk);
    issue(3'd7, 32'h33333333, 32'h1);
    wait_idle(n);
    chk("R12", "divide not disturbed cycles", n, 28);
    read_hl(h, l);
    chk("R12", "divide LO intact", l, 32'd9);
    chk("R12", "divide HI intact", h, 32'd0);

    finish_run();
  end
endmodule